// File: doc/BRIEF.md
# Host-Side Sampling Scheduler for a Two-Wire Serial ADC

This block sits in the host and runs a serial converter that has no busy pin. It raises a conversion-start line at the top of each sample frame and holds it high for the fixed conversion time. It then shifts in one 16-bit serial word and hands the 12-bit code to the system. The code is sign-extended or zero-extended to the output width, depending on whether the analog range is bipolar or unipolar. The start line falls when conversion ends, so the falling edge marks that a fresh result sits in the converter.

Two read schedules are offered. In optimum mode the read begins when conversion ends. It must finish at least a guard time before the next start edge, and the frame is stretched if the serial clock is too slow to fit. In fast mode the read overlaps the conversion and fetches the previous result, which allows a shorter frame. The sample period, serial clock half-period and both mode bits are live inputs. They are sampled once per frame, and the period is raised to the minimum that the chosen mode allows.

Top module: `adc_sample_scheduler`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `convst_o`, `sclk_o`, `sample_valid_o` and `frame_err_o` are 0 and `sample_o` is all zeros.
- R2: Each frame starts with a rising edge of `convst_o`. The line stays high for exactly CONV_CYC clock cycles and stays low for the rest of the frame. The first frame starts on the first clock edge after reset is released.
- R3: The frame length is the larger of `period_i` and a mode floor. In optimum mode the floor is CONV_CYC + max(32*H + QUIET_CYC, LOW_MIN_CYC). In fast mode it is CONV_CYC + max(ACQ_CYC, LOW_MIN_CYC). H is the effective serial half-period.
- R4: In optimum mode (`fast_mode_i`=0), the read starts on the clock edge where `convst_o` falls. `sclk_o` is never high while `convst_o` is high, nor during the last QUIET_CYC cycles of the frame.
- R5: In fast mode (`fast_mode_i`=1), the read starts on the same edge as the `convst_o` rise. H is limited to CONV_CYC/32, so the read ends before conversion ends. `sclk_o` is low on every falling edge of `convst_o`.
- R6: A read is 16 serial periods. Each period is H cycles low followed by H cycles high, with H = `sclk_div_i` and a value of 0 treated as 1. `sdata_i` is captured on the clock edge where `sclk_o` falls, and the first captured bit is the most significant.
- R7: `sample_valid_o` is a one-cycle pulse, one clock after the 16th capture. `sample_o` and `frame_err_o` change only together with that pulse.
- R8: The last 12 captured bits form the code, MSB first. With `bipolar_i`=1 the code is two's complement and bit 11 is copied into bits 15:12 of `sample_o`. With `bipolar_i`=0, bits 15:12 are zero.
- R9: `frame_err_o` is 1 when any of the first four captured bits is 1. The code is still delivered.
- R10: `fast_mode_i`, `bipolar_i`, `period_i` and `sclk_div_i` are sampled only on the edge that starts a frame. Changes inside a frame have no effect on that frame's timing or decoding.
- R11: `sclk_o` is low whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_mode_i | input | 1 | 1 = read during conversion, 0 = read after conversion |
| bipolar_i | input | 1 | 1 = two's complement coding, 0 = straight binary |
| period_i | input | PER_W | Requested frame length in clock cycles |
| sclk_div_i | input | DIV_W | Serial clock half-period in clock cycles |
| sdata_i | input | 1 | Serial data from the converter |
| convst_o | output | 1 | Conversion start, high during conversion |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| sample_o | output | OUT_W | Extended conversion result |
| sample_valid_o | output | 1 | One-cycle strobe for a new result |
| frame_err_o | output | 1 | Nonzero leading bits seen in the last word |

## Verification
The hardest situation to reach is a change of configuration in the middle of a frame. This covers switches between fast and optimum mode, and a new divider that would move both the frame floor and the start of the read. These changes must not disturb the frame already running. The stimulus reaches this by changing all four configuration inputs at irregular cycle offsets that drift across the frame boundary. A behavioural model in the bench samples them only at its own frame starts and is compared with every output on every cycle. Clamping of the fast-mode divider and the bipolar extremes 0x800 and 0x7FF are reached with fixed configurations before that phase.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;

    typedef struct packed {
        logic fast;
        logic bipolar;
    } frame_cfg_t;

    typedef enum logic {
        SCK_LOW  = 1'b0,
        SCK_HIGH = 1'b1
    } sck_phase_e;

    // effective serial half period: zero means one, fast mode is capped
    function automatic int unsigned pick_half(input int unsigned div,
                                              input logic fast,
                                              input int unsigned hmax);
        int unsigned h;
        h = (div == 0) ? 1 : div;
        if (fast && (h > hmax)) h = hmax;
        return h;
    endfunction

    // shortest legal frame for a mode and half period
    function automatic int unsigned frame_floor(input logic fast,
                                                input int unsigned half,
                                                input int unsigned conv,
                                                input int unsigned quiet,
                                                input int unsigned acq,
                                                input int unsigned lowmin,
                                                input int unsigned nclk);
        int unsigned tail;
        if (fast) begin
            tail = (acq > lowmin) ? acq : lowmin;
        end else begin
            tail = 2 * nclk * half + quiet;
            if (tail < lowmin) tail = lowmin;
        end
        return conv + tail;
    endfunction

endpackage

// File: rtl/adc_frame_timer.sv
module adc_frame_timer
    import adc_sched_pkg::*;
#(
    parameter int unsigned CONV_CYC    = 750,
    parameter int unsigned QUIET_CYC   = 75,
    parameter int unsigned ACQ_CYC     = 188,
    parameter int unsigned LOW_MIN_CYC = 7,
    parameter int unsigned NCLK        = 16,
    parameter int unsigned PER_W       = 16,
    parameter int unsigned DIV_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fast_i,
    input  logic             bipolar_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             convst_o,
    output frame_cfg_t       cfg_o,
    output logic [DIV_W-1:0] half_go_o,
    output logic             rd_go_o,
    output logic             quiet_o
);
    localparam int unsigned    HALF_MAX = CONV_CYC / (2 * NCLK);
    localparam logic [PER_W-1:0] CONV_P  = PER_W'(CONV_CYC);
    localparam logic [PER_W-1:0] QUIET_P = PER_W'(QUIET_CYC);
    localparam logic [PER_W-1:0] BASE_P  = PER_W'(CONV_CYC + LOW_MIN_CYC);

    logic [PER_W-1:0] pcnt_q, peff_q;
    logic             first_q, convst_q;
    frame_cfg_t       cfg_q;
    logic [DIV_W-1:0] half_q;

    logic             wrap;
    logic [PER_W-1:0] pcnt_nxt, floor_nxt, peff_nxt;
    logic [DIV_W-1:0] half_nxt;

    always_comb begin
        wrap      = first_q || (pcnt_q == peff_q - 1'b1);
        pcnt_nxt  = wrap ? '0 : pcnt_q + 1'b1;
        half_nxt  = DIV_W'(pick_half(32'(div_i), fast_i, HALF_MAX));
        floor_nxt = PER_W'(frame_floor(fast_i, 32'(half_nxt), CONV_CYC, QUIET_CYC,
                                       ACQ_CYC, LOW_MIN_CYC, NCLK));
        peff_nxt  = (period_i > floor_nxt) ? period_i : floor_nxt;
        half_go_o = wrap ? half_nxt : half_q;
        rd_go_o   = wrap ? fast_i : ((pcnt_nxt == CONV_P) && !cfg_q.fast);
        quiet_o   = !first_q && (pcnt_q >= peff_q - QUIET_P);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q   <= '0;
            peff_q   <= BASE_P;
            first_q  <= 1'b1;
            convst_q <= 1'b0;
            cfg_q    <= '0;
            half_q   <= DIV_W'(1);
        end else begin
            pcnt_q   <= pcnt_nxt;
            first_q  <= 1'b0;
            convst_q <= (pcnt_nxt < CONV_P);
            if (wrap) begin
                peff_q        <= peff_nxt;
                cfg_q.fast    <= fast_i;
                cfg_q.bipolar <= bipolar_i;
                half_q        <= half_nxt;
            end
        end
    end

    assign convst_o = convst_q;
    assign cfg_o    = cfg_q;

    AST_PEFF_FLOOR: assert property (@(posedge clk) disable iff (rst)
        peff_q >= BASE_P); // R3
    AST_FAST_HALF_CAP: assert property (@(posedge clk) disable iff (rst)
        cfg_q.fast |-> (32'(half_q) <= HALF_MAX)); // R5

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
    import adc_sched_pkg::*;
#(
    parameter int unsigned NBITS = 16,
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic [DIV_W-1:0] half_i,
    input  logic             sdata_i,
    output logic             sclk_o,
    output logic             done_o,
    output logic [NBITS-1:0] word_o
);
    localparam int unsigned    BCW  = $clog2(NBITS);
    localparam logic [BCW-1:0] LAST = BCW'(NBITS - 1);

    logic             busy_q, done_q;
    sck_phase_e       phase_q;
    logic [DIV_W-1:0] hcnt_q, h_q;
    logic [BCW-1:0]   bcnt_q;
    logic [NBITS-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            phase_q <= SCK_LOW;
            hcnt_q  <= '0;
            h_q     <= DIV_W'(1);
            bcnt_q  <= '0;
            shift_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (go_i) begin
                busy_q  <= 1'b1;
                phase_q <= SCK_LOW;
                hcnt_q  <= '0;
                bcnt_q  <= '0;
                h_q     <= half_i;
            end else if (busy_q) begin
                if (hcnt_q == h_q - 1'b1) begin
                    hcnt_q <= '0;
                    if (phase_q == SCK_LOW) begin
                        phase_q <= SCK_HIGH;
                    end else begin
                        phase_q <= SCK_LOW;
                        shift_q <= {shift_q[NBITS-2:0], sdata_i};
                        if (bcnt_q == LAST) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bcnt_q <= bcnt_q + 1'b1;
                        end
                    end
                end else begin
                    hcnt_q <= hcnt_q + 1'b1;
                end
            end
        end
    end

    assign sclk_o = (phase_q == SCK_HIGH);
    assign done_o = done_q;
    assign word_o = shift_q;

    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!sclk_o && $past(sclk_o))); // R6
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !sclk_o); // R11

endmodule

// File: rtl/adc_result_decode.sv
module adc_result_decode #(
    parameter int unsigned LEAD_W = 4,
    parameter int unsigned DATA_W = 12,
    parameter int unsigned OUT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     done_i,
    input  logic                     bipolar_i,
    input  logic [LEAD_W+DATA_W-1:0] word_i,
    output logic [OUT_W-1:0]         result_o,
    output logic                     valid_o,
    output logic                     ferr_o
);
    localparam int unsigned FRAME_W = LEAD_W + DATA_W;
    localparam int unsigned EXT_W   = OUT_W - DATA_W;

    logic [DATA_W-1:0] code;
    logic [LEAD_W-1:0] lead;
    logic [OUT_W-1:0]  ext;
    logic [OUT_W-1:0]  result_q;
    logic              valid_q, ferr_q;

    always_comb begin
        code = word_i[DATA_W-1:0];
        lead = word_i[FRAME_W-1 -: LEAD_W];
        ext  = {{EXT_W{bipolar_i & code[DATA_W-1]}}, code};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            valid_q  <= 1'b0;
            ferr_q   <= 1'b0;
        end else begin
            valid_q <= done_i;
            if (done_i) begin
                result_q <= ext;
                ferr_q   <= |lead;
            end
        end
    end

    assign result_o = result_q;
    assign valid_o  = valid_q;
    assign ferr_o   = ferr_q;

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q); // R7
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done_i |=> ($stable(result_q) && $stable(ferr_q))); // R7

endmodule

// File: rtl/adc_sample_scheduler.sv
module adc_sample_scheduler
    import adc_sched_pkg::*;
#(
    parameter int unsigned CONV_CYC    = 750,
    parameter int unsigned QUIET_CYC   = 75,
    parameter int unsigned ACQ_CYC     = 188,
    parameter int unsigned LOW_MIN_CYC = 7,
    parameter int unsigned PER_W       = 16,
    parameter int unsigned DIV_W       = 8,
    parameter int unsigned LEAD_W      = 4,
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned OUT_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fast_mode_i,
    input  logic             bipolar_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [DIV_W-1:0] sclk_div_i,
    input  logic             sdata_i,
    output logic             convst_o,
    output logic             sclk_o,
    output logic [OUT_W-1:0] sample_o,
    output logic             sample_valid_o,
    output logic             frame_err_o
);
    localparam int unsigned FRAME_W = LEAD_W + DATA_W;

    frame_cfg_t         cfg;
    logic [DIV_W-1:0]   half_go;
    logic               rd_go, quiet, done;
    logic [FRAME_W-1:0] word;

    adc_frame_timer #(
        .CONV_CYC(CONV_CYC), .QUIET_CYC(QUIET_CYC), .ACQ_CYC(ACQ_CYC),
        .LOW_MIN_CYC(LOW_MIN_CYC), .NCLK(FRAME_W), .PER_W(PER_W), .DIV_W(DIV_W)
    ) timer_i (
        .clk(clk), .rst(rst), .fast_i(fast_mode_i), .bipolar_i(bipolar_i),
        .period_i(period_i), .div_i(sclk_div_i), .convst_o(convst_o),
        .cfg_o(cfg), .half_go_o(half_go), .rd_go_o(rd_go), .quiet_o(quiet)
    );

    adc_serial_reader #(
        .NBITS(FRAME_W), .DIV_W(DIV_W)
    ) reader_i (
        .clk(clk), .rst(rst), .go_i(rd_go), .half_i(half_go), .sdata_i(sdata_i),
        .sclk_o(sclk_o), .done_o(done), .word_o(word)
    );

    adc_result_decode #(
        .LEAD_W(LEAD_W), .DATA_W(DATA_W), .OUT_W(OUT_W)
    ) decode_i (
        .clk(clk), .rst(rst), .done_i(done), .bipolar_i(cfg.bipolar),
        .word_i(word), .result_o(sample_o), .valid_o(sample_valid_o),
        .ferr_o(frame_err_o)
    );

    AST_OPT_NO_SCLK_IN_CONV: assert property (@(posedge clk) disable iff (rst)
        (!cfg.fast && convst_o) |-> !sclk_o); // R4
    AST_QUIET_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (!cfg.fast && quiet) |-> !sclk_o); // R4
    AST_SCLK_LOW_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(convst_o) |-> !sclk_o); // R5

endmodule

// File: tb/adc_sample_scheduler_tb_top.sv
`timescale 1ns/1ps
module adc_sample_scheduler_tb_top;
    localparam int CONV  = 64;
    localparam int QUIET = 8;
    localparam int ACQ   = 20;
    localparam int LOWM  = 4;
    localparam int HMAXF = CONV / 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fast_mode = 1'b0;
    logic        bip = 1'b0;
    logic [15:0] period = '0;
    logic [7:0]  div = 8'd2;
    logic        sdata = 1'b0;
    logic        convst_o, sclk_o, sample_valid_o, frame_err_o;
    logic [15:0] sample_o;

    always #4 clk = ~clk;

    adc_sample_scheduler #(
        .CONV_CYC(CONV), .QUIET_CYC(QUIET), .ACQ_CYC(ACQ), .LOW_MIN_CYC(LOWM),
        .PER_W(16), .DIV_W(8), .LEAD_W(4), .DATA_W(12), .OUT_W(16)
    ) dut_i (
        .clk(clk), .rst(rst), .fast_mode_i(fast_mode), .bipolar_i(bip),
        .period_i(period), .sclk_div_i(div), .sdata_i(sdata),
        .convst_o(convst_o), .sclk_o(sclk_o), .sample_o(sample_o),
        .sample_valid_o(sample_valid_o), .frame_err_o(frame_err_o)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit run_chk = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] decode(input logic [15:0] w, input logic b);
        logic [11:0] c;
        c = w[11:0];
        return (b && c[11]) ? {4'hF, c} : {4'h0, c};
    endfunction

    // reference model, evaluated on each rising edge
    bit m_first = 1, m_fast = 0, m_bip = 0, m_read = 0, m_pend = 0;
    int m_pos = 0, m_peff = 0, m_prevpeff = 0, m_t = 0, m_h = 1;
    logic [15:0] m_bits = '0;
    bit e_convst = 0, e_sclk = 0, e_valid = 0, e_ferr = 0;
    logic [15:0] e_res = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_first = 1; m_read = 0; m_pend = 0; m_pos = 0;
            e_convst = 0; e_sclk = 0; e_valid = 0; e_ferr = 0; e_res = '0;
        end else begin
            bit nf;
            int h, fl;
            e_valid = m_pend;
            if (m_pend) begin
                e_res  = decode(m_bits, m_bip);
                e_ferr = (m_bits[15:12] != 0);
            end
            m_pend = 0;
            if (m_read) begin
                m_t++;
                if (m_t % (2 * m_h) == 0) m_bits = {m_bits[14:0], sdata};
                if (m_t == 32 * m_h) begin m_read = 0; m_pend = 1; end
            end
            nf = 0;
            if (m_first || m_pos == m_peff - 1) begin
                nf = 1; m_first = 0; m_pos = 0;
                m_fast = fast_mode; m_bip = bip;
                h = (div == 0) ? 1 : int'(div);
                if (m_fast && h > HMAXF) h = HMAXF;
                if (m_fast) fl = CONV + ((ACQ > LOWM) ? ACQ : LOWM);
                else fl = CONV + ((32 * h + QUIET > LOWM) ? 32 * h + QUIET : LOWM);
                m_prevpeff = m_peff;
                m_peff = (int'(period) > fl) ? int'(period) : fl;
                m_h = h;
            end else begin
                m_pos++;
            end
            e_convst = (m_pos < CONV);
            if ((nf && m_fast) || (!nf && m_pos == CONV && !m_fast)) begin
                m_read = 1; m_t = 0;
            end
            e_sclk = m_read && ((m_t / m_h) % 2 == 1);
        end
    end

    // converter model and per-cycle comparison, on falling edges
    bit prev_convst = 0, prev_sclk = 0;
    int adc_idx = 0, adc_bit = 0, last_rise = -1;
    logic [3:0]  inject_lead = 4'h0;
    logic [15:0] adc_word = 16'h0123, adc_tx_word = '0;

    function automatic logic [15:0] mk(input int i, input logic [3:0] ld);
        logic [11:0] c;
        case (i % 6)
            0: c = 12'h800;
            1: c = 12'h7FF;
            2: c = 12'hFFF;
            3: c = 12'h000;
            4: c = 12'h5A3;
            default: c = 12'(i * 1237 + 91);
        endcase
        return {ld, c};
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (run_chk && !rst) begin
            chk(convst_o === e_convst, "R2 convst_o", convst_o, e_convst);
            chk(sclk_o === e_sclk, "R6 sclk_o", sclk_o, e_sclk);
            chk(sample_valid_o === e_valid, "R7 sample_valid_o", sample_valid_o, e_valid);
            chk(sample_o === e_res, "R8 sample_o", sample_o, e_res);
            chk(frame_err_o === e_ferr, "R9 frame_err_o", frame_err_o, e_ferr);
            if (!m_fast && !m_first && (m_pos < CONV || m_pos >= m_peff - QUIET))
                chk(!sclk_o, "R4 sclk in guarded window", sclk_o, 0);
            if (prev_convst && !convst_o)
                chk(!sclk_o, "R5 sclk at convst fall", sclk_o, 0);
            if (!m_read)
                chk(!sclk_o, "R11 sclk idle", sclk_o, 0);
            if (!prev_convst && convst_o) begin
                if (last_rise >= 0)
                    chk(cyc - last_rise == m_prevpeff, "R3 frame length", cyc - last_rise, m_prevpeff);
                last_rise = cyc;
            end
            if (sample_valid_o) begin
                chk(sample_o === decode(adc_tx_word, m_bip), "R8 result vs sent word",
                    sample_o, decode(adc_tx_word, m_bip));
                chk(frame_err_o === (adc_tx_word[15:12] != 0), "R9 flag vs sent word",
                    frame_err_o, adc_tx_word[15:12] != 0);
            end
        end
        if (prev_convst && !convst_o) begin
            adc_idx++;
            adc_word = mk(adc_idx, inject_lead);
            adc_bit = 0;
        end
        if (sclk_o && !prev_sclk) begin
            if (adc_bit == 0) adc_tx_word = adc_word;
            sdata = adc_word[15 - adc_bit];
            adc_bit = (adc_bit + 1) % 16;
        end
        prev_sclk = sclk_o;
        prev_convst = convst_o;
    end

    task automatic frames(input int n);
        repeat (n) @(posedge convst_o);
        @(negedge clk);
    endtask

    initial begin
        int err_before;
        repeat (4) @(negedge clk);
        chk(convst_o === 0 && sclk_o === 0, "R1 lines in reset", {convst_o, sclk_o}, 0);
        chk(sample_valid_o === 0 && frame_err_o === 0, "R1 flags in reset",
            {sample_valid_o, frame_err_o}, 0);
        chk(sample_o === 16'h0, "R1 sample in reset", sample_o, 0);
        rst = 1'b0;
        run_chk = 1;
        // optimum, unipolar, clamped period
        fast_mode = 0; bip = 0; div = 8'd2; period = 16'd0;
        frames(7);
        // optimum, bipolar, long period, fastest serial clock
        bip = 1; div = 8'd1; period = 16'd300;
        frames(7);
        // framing error injection
        inject_lead = 4'h5;
        frames(3);
        inject_lead = 4'h0;
        frames(2);
        // fast mode with divider above the cap
        fast_mode = 1; div = 8'd5; period = 16'd0;
        frames(7);
        // fast mode, unipolar, explicit period
        bip = 0; div = 8'd1; period = 16'd120;
        frames(6);
        // divider zero in optimum mode
        fast_mode = 0; div = 8'd0; period = 16'd0; bip = 1;
        frames(6);
        // configuration changes at drifting offsets inside frames (R10)
        err_before = n_err;
        for (int i = 0; i < 14; i++) begin
            repeat (37 + i * 23) @(negedge clk);
            fast_mode = i[0];
            bip = i[1];
            div = 8'(i % 4);
            period = (i % 3 == 0) ? 16'd0 : 16'd210;
        end
        frames(3);
        chk(n_err == err_before, "R10 mid-frame config changes", n_err - err_before, 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    always @(posedge clk) begin
        if (!finished && cyc > 150000) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule